// File: doc/BRIEF.md
# Dot-Clock LCD Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, advancing one pixel position per clock. Two counters walk the frame: a pixel counter that restarts at the end of every line and a line counter that steps each time the pixel counter restarts. The counter values are decoded into sync pulses and an active-data window, each with its own polarity. The active window is placed by wait counts measured from the leading edge of sync, so each wait count already includes the sync width. A pulse marks the first active pixel of every frame.

Software programs the block through a small word-addressed register file. Every register has three write views: a plain write, an OR view that sets the written bits, and a clear view that drops them. A frame-base address register feeds a current-base output. The new value is adopted only at the start of a frame, so a buffer flip never tears a picture. Clearing the run bit does not stop the block at once. The counters keep going until an external indication says the pending pixel data has drained, and the run status then falls.

Top module: `lcd_sync_gen`

## Requirements
- R1: Register access uses byte address bits [7:4] as the register index. Index 0 is control, 1 frame lines, 2 vsync width in lines, 3 line period in clocks, 4 hsync width, 5 horizontal wait, 6 vertical wait, 7 active pixels per line, 8 active lines, 9 next frame base. Bits [3:2] pick the action: 0 writes the value, 1 ORs the data into the register, 2 clears the bits that are set in the data, and 3 is ignored. A write with bits [1:0] not zero is ignored. Control bits: 0 run, 1 sync enable, 2 hsync active-high, 3 vsync active-high, 4 data-enable active-high, 5 falling-edge sampling.
- R2: Hsync is active for the programmed hsync width, starting at pixel 0 of every line. It repeats every line-period clocks.
- R3: Vsync is active for the first vsync-width lines of each frame, counted in whole lines. A frame lasts frame-lines times line-period clocks.
- R4: Data enable is active when the pixel index h satisfies hwait <= h < hwait+active pixels and the line index v satisfies vwait <= v < vwait+active lines. Both indices count from the start of their sync.
- R5: Each of hsync, vsync and data enable is driven high when active if its polarity bit is 1, and driven low when active if the bit is 0. The inactive level is the opposite.
- R6: While sync enable is clear, or the block is not running, hsync, vsync and data enable stay at their inactive levels and the first-pixel pulse stays low.
- R7: The current base takes the next-base value only at the frame start, in the same cycle vsync turns active. A next-base write in the middle of a frame leaves the current base unchanged until the following frame.
- R8: Run status rises one clock after the run bit is set. After the run bit is cleared, run status stays 1 until drain-empty is high, and falls on the next clock. A later start begins again at pixel 0 of line 0.
- R9: The first-pixel output pulses high for one clock, together with the first data-enable pixel of each frame.
- R10: The falling-edge select output follows control bit 5 as soon as that bit is written.
- R11: If the write that sets run lands on clock edge E0, run status reads 1 after E0+1 and pixel 0 of line 0 appears on the outputs after E0+2. Each later pixel appears one clock after the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | 32 | Write data |
| drain_empty | input | 1 | High when no pending pixel data remains |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| data_en | output | 1 | Active-data strobe, polarity applied |
| first_pixel | output | 1 | Active-high pulse on the first active pixel of a frame |
| run_status | output | 1 | Counters running |
| pix_edge_fall | output | 1 | Falling-edge sampling select |
| cur_base | output | BASE_W | Frame base address in use |

## Verification
Run status is due one clock after the edge where the run write lands. Pixel 0 reaches the outputs on the second edge after that write, so the bench samples at the falling edge and takes the second sample after the write as pixel 0. From that sample on, every falling-edge sample is compared with a value computed from the pixel and line indices of that position, for two full frames. This covers the pulse widths, periods, data-enable window, first-pixel pulse and the base swap. The base swap is expected on the first sample of the second frame, because the mid-frame write lands long before that frame starts. Gating and drain effects are checked from the first falling edge after the write that causes them.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

   localparam int NUM_REGS     = 10;
   localparam int RI_CTRL      = 0;
   localparam int RI_VTOTAL    = 1;
   localparam int RI_VSW       = 2;
   localparam int RI_HTOTAL    = 3;
   localparam int RI_HSW       = 4;
   localparam int RI_HWAIT     = 5;
   localparam int RI_VWAIT     = 6;
   localparam int RI_HACT      = 7;
   localparam int RI_VACT      = 8;
   localparam int RI_NEXT_BASE = 9;

   localparam int CB_RUN      = 0;
   localparam int CB_SYNC_EN  = 1;
   localparam int CB_HS_HIGH  = 2;
   localparam int CB_VS_HIGH  = 3;
   localparam int CB_DE_HIGH  = 4;
   localparam int CB_CLK_FALL = 5;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_NONE  = 2'd3
   } reg_op_e;

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
   } pol_t;

endpackage

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
   import lcd_sync_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
   localparam int IDX_W = ADDR_W - 4;

   if (IDX_W < 1 || (2 ** IDX_W) < NUM_REGS) begin : g_bad_addr
      $error("lcd_sync_regs: ADDR_W too small for the register set");
   end

   logic [IDX_W-1:0] sel;
   reg_op_e          op;
   logic             aligned;

   assign sel     = addr[ADDR_W-1:4];
   assign op      = reg_op_e'(addr[3:2]);
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      assign hit = we && aligned && (sel == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (hit) begin
            case (op)
               OP_WRITE: regs_q[i] <= wdata;
               OP_SET:   regs_q[i] <= regs_q[i] | wdata;
               OP_CLEAR: regs_q[i] <= regs_q[i] & ~wdata;
               default:  regs_q[i] <= regs_q[i];
            endcase
         end
      end

      // R1: an ignored action (op 3) or a misaligned address leaves the register alone
      p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (we && (sel == IDX_W'(i)) && (!aligned || op == OP_NONE)) |=> $stable(regs_q[i]));
   end

endmodule

// File: rtl/lcd_sync_count.sv
module lcd_sync_count #(
   parameter int H_W = 18,
   parameter int V_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [H_W-1:0] h_total,
   input  logic [V_W-1:0] v_total,
   output logic [H_W-1:0] h,
   output logic [V_W-1:0] v,
   output logic           frame_start
);
   logic h_wrap;
   logic v_wrap;

   // Wrap when the next index would reach the total; totals of 0 or 1 hold at 0.
   assign h_wrap      = ({1'b0, h} + 1'b1) >= {1'b0, h_total};
   assign v_wrap      = ({1'b0, v} + 1'b1) >= {1'b0, v_total};
   assign frame_start = run && (h == '0) && (v == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         h <= '0;
         v <= '0;
      end else if (h_wrap) begin
         h <= '0;
         v <= v_wrap ? '0 : v + 1'b1;
      end else begin
         h <= h + 1'b1;
      end
   end

   // R2: while running, the pixel index only steps by one or restarts at zero
   p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ((h == H_W'($past(h) + 1'b1)) || (h == '0)));

   // R3: the line index can only move on a cycle where the pixel index restarts
   p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (h != '0) |-> $stable(v));

endmodule

// File: rtl/lcd_sync_out.sv
module lcd_sync_out
   import lcd_sync_pkg::*;
#(
   parameter int H_W     = 18,
   parameter int V_W     = 16,
   parameter int HSW_W   = 14,
   parameter int VSW_W   = 18,
   parameter int HWAIT_W = 12,
   parameter int VWAIT_W = 16,
   parameter bit OUT_PIPE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               sync_en,
   input  pol_t               pol,
   input  logic [H_W-1:0]     h,
   input  logic [V_W-1:0]     v,
   input  logic [HSW_W-1:0]   hsw,
   input  logic [VSW_W-1:0]   vsw,
   input  logic [HWAIT_W-1:0] hwait,
   input  logic [VWAIT_W-1:0] vwait,
   input  logic [H_W-1:0]     hact,
   input  logic [V_W-1:0]     vact,
   output logic               hs_o,
   output logic               vs_o,
   output logic               de_o,
   output logic               first_o
);
   localparam int HX = H_W + 1;
   localparam int VX = ((VSW_W > V_W) ? VSW_W : V_W) + 1;

   if (HSW_W > H_W || HWAIT_W > H_W) begin : g_bad_h
      $error("lcd_sync_out: horizontal fields wider than the pixel counter");
   end
   if (VWAIT_W > V_W) begin : g_bad_v
      $error("lcd_sync_out: vertical wait wider than the line counter");
   end

   logic [HX-1:0] hx, hde_end;
   logic [VX-1:0] vx, vde_end;
   logic          hs_act, vs_act, de_act, first_act, drive;
   logic          hs_n, vs_n, de_n, first_n;

   assign hx      = HX'(h);
   assign vx      = VX'(v);
   assign hde_end = HX'(hwait) + HX'(hact);
   assign vde_end = VX'(vwait) + VX'(vact);

   assign hs_act    = hx < HX'(hsw);
   assign vs_act    = vx < VX'(vsw);
   assign de_act    = (hx >= HX'(hwait)) && (hx < hde_end) &&
                      (vx >= VX'(vwait)) && (vx < vde_end);
   assign first_act = de_act && (hx == HX'(hwait)) && (vx == VX'(vwait));
   assign drive     = run && sync_en;

   assign hs_n    = (drive && hs_act) ? pol.hs : !pol.hs;
   assign vs_n    = (drive && vs_act) ? pol.vs : !pol.vs;
   assign de_n    = (drive && de_act) ? pol.de : !pol.de;
   assign first_n = drive && first_act;

   if (OUT_PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hs_o    <= 1'b1;
            vs_o    <= 1'b1;
            de_o    <= 1'b1;
            first_o <= 1'b0;
         end else begin
            hs_o    <= hs_n;
            vs_o    <= vs_n;
            de_o    <= de_n;
            first_o <= first_n;
         end
      end

      // R6: with the drive gate off, every strobe sits at its inactive level next cycle
      p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(run && sync_en) |=> ((hs_o == !$past(pol.hs)) && (vs_o == !$past(pol.vs)) &&
                                (de_o == !$past(pol.de)) && !first_o));

      // R9: the first-pixel pulse always coincides with an active data-enable level
      p_first_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
         first_o |-> (de_o == $past(pol.de)));
   end else begin : g_comb
      assign hs_o    = hs_n;
      assign vs_o    = vs_n;
      assign de_o    = de_n;
      assign first_o = first_n;
   end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
   import lcd_sync_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int H_W     = 18,
   parameter int V_W     = 16,
   parameter int HSW_W   = 14,
   parameter int VSW_W   = 18,
   parameter int HWAIT_W = 12,
   parameter int VWAIT_W = 16,
   parameter int BASE_W  = 32,
   parameter bit OUT_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              drain_empty,
   output logic              hsync,
   output logic              vsync,
   output logic              data_en,
   output logic              first_pixel,
   output logic              run_status,
   output logic              pix_edge_fall,
   output logic [BASE_W-1:0] cur_base
);
   localparam int DATA_W = 32;

   if (H_W > DATA_W || V_W > DATA_W || VSW_W > DATA_W || BASE_W > DATA_W) begin : g_bad_w
      $error("lcd_sync_gen: a field is wider than a register word");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [DATA_W-1:0]               ctrl;
   logic                            run_q;
   logic [H_W-1:0]                  h;
   logic [V_W-1:0]                  v;
   logic                            frame_start;
   pol_t                            pol;
   logic                            unused_regs;

   lcd_sync_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .regs_q (regs_q)
   );

   assign ctrl          = regs_q[RI_CTRL];
   assign pol.hs        = ctrl[CB_HS_HIGH];
   assign pol.vs        = ctrl[CB_VS_HIGH];
   assign pol.de        = ctrl[CB_DE_HIGH];
   assign pix_edge_fall = ctrl[CB_CLK_FALL];
   assign unused_regs   = ^regs_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               run_q <= 1'b0;
      else if (ctrl[CB_RUN])    run_q <= 1'b1;
      else if (drain_empty)     run_q <= 1'b0;
   end
   assign run_status = run_q;

   lcd_sync_count #(.H_W(H_W), .V_W(V_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .h_total     (regs_q[RI_HTOTAL][H_W-1:0]),
      .v_total     (regs_q[RI_VTOTAL][V_W-1:0]),
      .h           (h),
      .v           (v),
      .frame_start (frame_start)
   );

   lcd_sync_out #(
      .H_W(H_W), .V_W(V_W), .HSW_W(HSW_W), .VSW_W(VSW_W),
      .HWAIT_W(HWAIT_W), .VWAIT_W(VWAIT_W), .OUT_PIPE(OUT_PIPE)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .sync_en (ctrl[CB_SYNC_EN]),
      .pol     (pol),
      .h       (h),
      .v       (v),
      .hsw     (regs_q[RI_HSW][HSW_W-1:0]),
      .vsw     (regs_q[RI_VSW][VSW_W-1:0]),
      .hwait   (regs_q[RI_HWAIT][HWAIT_W-1:0]),
      .vwait   (regs_q[RI_VWAIT][VWAIT_W-1:0]),
      .hact    (regs_q[RI_HACT][H_W-1:0]),
      .vact    (regs_q[RI_VACT][V_W-1:0]),
      .hs_o    (hsync),
      .vs_o    (vsync),
      .de_o    (data_en),
      .first_o (first_pixel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           cur_base <= '0;
      else if (frame_start) cur_base <= regs_q[RI_NEXT_BASE][BASE_W-1:0];
   end

   // R7: the base in use moves only on a frame-start cycle
   p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_base) |-> $past(frame_start));

   // R8: run status drops only once run is clear and the pending data has drained
   p_fall_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(drain_empty) && !$past(ctrl[CB_RUN])));

   // R8: run status rises only after the run bit was set
   p_rise_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(ctrl[CB_RUN]));

endmodule

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
   import lcd_sync_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        drain_empty;
   logic        hsync, vsync, data_en, first_pixel, run_status, pix_edge_fall;
   logic [31:0] cur_base;

   int  vectors = 0;
   int  fails   = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   lcd_sync_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .drain_empty(drain_empty), .hsync(hsync),
      .vsync(vsync), .data_en(data_en), .first_pixel(first_pixel),
      .run_status(run_status), .pix_edge_fall(pix_edge_fall), .cur_base(cur_base)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         if (fails <= 25)
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr(input int idx, input int op, input logic [31:0] d);
      wr_raw(8'(idx * 16 + op * 4), d);
   endtask

   function automatic logic lvl(input bit act, input bit pol);
      return act ? pol : !pol;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R11 watchdog actual=expired expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      int hsw, hwait, hact, hper, vsw, vwait, vact, vtot, frame;
      bit phs, pvs, pde, cf;
      logic [31:0] base_x, base_y, ctrl0;

      seed_dummy = $urandom(32'd20240611);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; drain_empty = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: active-low defaults, so every strobe idles high
      chk("R8 reset run_status", run_status, 0);
      chk("R5 reset hsync", hsync, 1);
      chk("R5 reset vsync", vsync, 1);
      chk("R5 reset data_en", data_en, 1);
      chk("R9 reset first_pixel", first_pixel, 0);
      chk("R7 reset cur_base", cur_base, 0);
      chk("R10 reset pix_edge_fall", pix_edge_fall, 0);

      for (int it = 0; it < 4; it++) begin
         if (it < 3) begin
            hsw   = 1 + int'($urandom % 4);
            hwait = hsw + int'($urandom % 4);
            hact  = 4 + int'($urandom % 8);
            hper  = hwait + hact + int'($urandom % 5);
            vsw   = 1 + int'($urandom % 2);
            vwait = vsw + int'($urandom % 2);
            vact  = 2 + int'($urandom % 3);
            vtot  = vwait + vact + int'($urandom % 2);
         end else begin
            // corner: wait equals sync width and the window runs to the end of line and frame
            hsw = 1; hwait = 1; hper = 10; hact = 9;
            vsw = 1; vwait = 1; vtot = 4;  vact = 3;
         end
         frame = hper * vtot;
         phs = 1'($urandom); pvs = 1'($urandom); pde = 1'($urandom); cf = 1'($urandom);
         if (it == 0) begin phs = 1'b1; pvs = 1'b0; end
         base_x = $urandom; base_y = $urandom;
         ctrl0 = (32'd1 << CB_SYNC_EN) | (32'(phs) << CB_HS_HIGH) | (32'(pvs) << CB_VS_HIGH) |
                 (32'(pde) << CB_DE_HIGH) | (32'(cf) << CB_CLK_FALL);

         drain_empty = 1'b1;
         wr(RI_CTRL, OP_WRITE, ctrl0);
         chk("R10 edge select follows bit 5", pix_edge_fall, 32'(cf));
         wr(RI_HTOTAL, OP_WRITE, hper);
         wr(RI_HSW,    OP_WRITE, hsw);
         wr(RI_HWAIT,  OP_WRITE, hwait);
         wr(RI_HACT,   OP_WRITE, hact);
         wr(RI_VTOTAL, OP_WRITE, vtot);
         wr(RI_VSW,    OP_WRITE, vsw);
         wr(RI_VWAIT,  OP_WRITE, vwait);
         wr(RI_VACT,   OP_WRITE, vact);
         wr(RI_NEXT_BASE, OP_WRITE, base_x);

         // R1: op 3 and a misaligned address must not touch control
         wr(RI_CTRL, 3, 32'hFFFF_FFFF);
         wr_raw(8'h01, 32'hFFFF_FFFF);
         @(negedge clk);
         chk("R1 ignored writes keep run clear", run_status, 0);
         chk("R1 ignored writes keep edge select", pix_edge_fall, 32'(cf));

         // R1: OR view sets run and keeps the other control bits
         wr(RI_CTRL, OP_SET, 32'd1 << CB_RUN);
         @(negedge clk);
         chk("R11 run_status one clock after run write", run_status, 1);
         chk("R11 hsync idle before pixel 0", hsync, 32'(!phs));
         @(negedge clk);

         for (int t = 0; t < 2 * frame + 8; t++) begin
            int h, v;
            bit hs_a, vs_a, de_a, fp;
            h = t % hper;
            v = (t / hper) % vtot;
            hs_a = (h < hsw);
            vs_a = (v < vsw);
            de_a = (h >= hwait) && (h < hwait + hact) && (v >= vwait) && (v < vwait + vact);
            fp   = de_a && (h == hwait) && (v == vwait);
            chk("R2/R5 hsync", hsync, 32'(lvl(hs_a, phs)));
            chk("R3/R5 vsync", vsync, 32'(lvl(vs_a, pvs)));
            chk("R4/R5 data_en", data_en, 32'(lvl(de_a, pde)));
            chk("R9 first_pixel", first_pixel, 32'(fp));
            chk("R7 cur_base", cur_base, (t < frame) ? base_x : base_y);
            if (t == frame / 2) begin
               cfg_we = 1'b1; cfg_addr = 8'(RI_NEXT_BASE * 16); cfg_wdata = base_y;
            end else begin
               cfg_we = 1'b0;
            end
            @(negedge clk);
         end
         cfg_we = 1'b0;

         // R6: drop sync enable through the clear view; strobes idle
         wr(RI_CTRL, OP_CLEAR, 32'd1 << CB_SYNC_EN);
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R6 hsync idle", hsync, 32'(!phs));
            chk("R6 vsync idle", vsync, 32'(!pvs));
            chk("R6 data_en idle", data_en, 32'(!pde));
            chk("R6 first_pixel low", first_pixel, 0);
         end
         chk("R1 clear view keeps run set", run_status, 1);

         // R8: stop waits for the drain
         drain_empty = 1'b0;
         wr(RI_CTRL, OP_CLEAR, 32'd1 << CB_RUN);
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 run_status held while draining", run_status, 1);
         end
         drain_empty = 1'b1;
         @(negedge clk);
         chk("R8 run_status falls after drain", run_status, 0);
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule